// File: doc/BRIEF.md
# Two-Byte Sample Frame Decoder

This block sits behind a serial byte receiver and rebuilds 10-bit readings from a multi-channel converter. Each reading travels as two bytes: an upper half holding bits 9..5 and a lower half holding bits 4..0. Every byte carries its own half flag and a 2-bit channel code, so the stream can interleave channels in any order.

The stream has no checksum. The only integrity rule is pairing: an upper half must be followed, as the next accepted byte, by the lower half of the same channel. A byte that breaks this rule is flushed and a one-cycle error strobe is raised. A correct pair produces a one-cycle sample strobe together with the 10-bit value and the channel code. Idle cycles between the halves are allowed.

Top module: `frame_pair_decoder`

## Requirements
- R1: A synchronous active-high reset clears the pending upper half and drives `smp_stb` and `err_stb` low; a lower half that arrives first after reset is treated as an orphan.
- R2: Byte layout: bit 7 is the half flag (0 = upper half, 1 = lower half), bits 6:5 are the channel code (00 = first channel, 11 = fourth channel), bits 4:0 are five data bits.
- R3: When a lower half arrives while an upper half of the same channel is pending, `smp_stb` is high in the cycle after that byte is accepted, `smp_val` equals upper data times 32 plus lower data, and `smp_chan` equals the channel code.
- R4: Pairs of different channels may follow each other in any order, back to back, and each decodes correctly.
- R5: A lower half that arrives with nothing pending raises `err_stb` for one cycle, one cycle after acceptance, and produces no sample.
- R6: A lower half whose channel differs from the pending upper half raises `err_stb` once, produces no sample, and empties the pending state, so a later lower half of the original channel is also an orphan.
- R7: An upper half that arrives while another upper half is pending raises `err_stb` once and replaces the pending byte; a following matching lower half pairs with the new upper half.
- R8: Cycles with `byte_vld` low are ignored: they change neither the pending state nor the outputs, whatever is on `byte_in`.
- R9: `smp_stb` and `err_stb` are never high in the same cycle, and each lasts one cycle per accepted byte.
- R10: The reading 564 on the fourth channel (upper data 10001b, lower data 10100b, bytes 0x71 then 0xF4) decodes to `smp_val` = 564, `smp_chan` = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Byte strobe from the serial receiver |
| byte_in | input | 8 | Received byte |
| smp_stb | output | 1 | One-cycle strobe: a sample is complete |
| smp_val | output | 10 | Rebuilt sample, valid with `smp_stb` |
| smp_chan | output | 2 | Channel code of the sample |
| err_stb | output | 1 | One-cycle strobe: a byte was flushed |

## Verification
The case where two functions meet in one cycle is the repeated upper half: the same edge that raises the error strobe must also capture the new byte as the pending half. The bench provokes it with upper halves of both different and equal channels in a row, then sends a lower half matching only the newer one, and judges it by the error pulse on the second upper half followed by a sample built from the newer data. A mismatched lower half is judged the same way from the other side: its error pulse must leave nothing pending, which a trailing lower half of the first channel exposes as a second error.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    localparam int HALF_W_DEF = 5;
    localparam int CH_W_DEF   = 2;

    // Outcome of one clock's byte decision
    typedef enum logic [2:0] {
        EV_IDLE     = 3'd0,
        EV_CAPTURE  = 3'd1,
        EV_PAIR     = 3'd2,
        EV_ORPHAN   = 3'd3,
        EV_MISMATCH = 3'd4,
        EV_REPLACE  = 3'd5
    } fpd_event_e;

    function automatic fpd_event_e fpd_classify(
        input logic vld,
        input logic is_lower,
        input logic pending,
        input logic same_chan
    );
        fpd_event_e ev;
        if (!vld)
            ev = EV_IDLE;
        else if (!is_lower)
            ev = pending ? EV_REPLACE : EV_CAPTURE;
        else if (!pending)
            ev = EV_ORPHAN;
        else if (same_chan)
            ev = EV_PAIR;
        else
            ev = EV_MISMATCH;
        return ev;
    endfunction

    function automatic logic fpd_is_fault(input fpd_event_e ev);
        return (ev == EV_ORPHAN) || (ev == EV_MISMATCH) || (ev == EV_REPLACE);
    endfunction

endpackage

// File: rtl/fpd_field_split.sv
module fpd_field_split #(
    parameter int HALF_W = fpd_pkg::HALF_W_DEF,
    parameter int CH_W   = fpd_pkg::CH_W_DEF,
    localparam int BYTE_W = 1 + CH_W + HALF_W
) (
    input  logic [BYTE_W-1:0] raw,
    output logic              is_lower,
    output logic [CH_W-1:0]   chan,
    output logic [HALF_W-1:0] data
);
    typedef struct packed {
        logic              lower;
        logic [CH_W-1:0]   chan;
        logic [HALF_W-1:0] data;
    } fields_t;

    fields_t f;

    always_comb begin
        f        = fields_t'(raw);
        is_lower = f.lower;
        chan     = f.chan;
        data     = f.data;
    end
endmodule

// File: rtl/fpd_pair_track.sv
module fpd_pair_track
    import fpd_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    parameter int CH_W   = CH_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic              is_lower,
    input  logic [CH_W-1:0]   chan,
    input  logic [HALF_W-1:0] data,
    output fpd_event_e        ev,
    output logic              pend_q,
    output logic [CH_W-1:0]   pend_chan_q,
    output logic [HALF_W-1:0] pend_data_q
);
    logic same_chan;

    assign same_chan = (chan == pend_chan_q);

    always_comb begin
        ev = fpd_classify(vld, is_lower, pend_q, same_chan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_chan_q <= '0;
            pend_data_q <= '0;
        end else begin
            unique case (ev)
                EV_CAPTURE, EV_REPLACE: begin
                    pend_q      <= 1'b1;
                    pend_chan_q <= chan;
                    pend_data_q <= data;
                end
                EV_PAIR, EV_MISMATCH: pend_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> ($stable(pend_q) && $stable(pend_chan_q) && $stable(pend_data_q)));

    // R7
    replace_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !is_lower) |=> (pend_q && pend_chan_q == $past(chan) && pend_data_q == $past(data)));

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && is_lower) |=> !pend_q);
endmodule

// File: rtl/fpd_emit.sv
module fpd_emit
    import fpd_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    parameter int CH_W   = CH_W_DEF,
    localparam int SAMP_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  fpd_event_e        ev,
    input  logic [HALF_W-1:0] hi_data,
    input  logic [HALF_W-1:0] lo_data,
    input  logic [CH_W-1:0]   chan,
    output logic              smp_stb,
    output logic [SAMP_W-1:0] smp_val,
    output logic [CH_W-1:0]   smp_chan,
    output logic              err_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_stb  <= 1'b0;
            err_stb  <= 1'b0;
            smp_val  <= '0;
            smp_chan <= '0;
        end else begin
            smp_stb <= (ev == EV_PAIR);
            err_stb <= fpd_is_fault(ev);
            if (ev == EV_PAIR) begin
                smp_val  <= {hi_data, lo_data};
                smp_chan <= chan;
            end
        end
    end

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(smp_stb && err_stb));
endmodule

// File: rtl/frame_pair_decoder.sv
module frame_pair_decoder
    import fpd_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    parameter int CH_W   = CH_W_DEF,
    localparam int BYTE_W = 1 + CH_W + HALF_W,
    localparam int SAMP_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              smp_stb,
    output logic [SAMP_W-1:0] smp_val,
    output logic [CH_W-1:0]   smp_chan,
    output logic              err_stb
);
    logic              b_lower;
    logic [CH_W-1:0]   b_chan;
    logic [HALF_W-1:0] b_data;
    fpd_event_e        ev;
    logic              pend_q;
    logic [CH_W-1:0]   pend_chan_q;
    logic [HALF_W-1:0] pend_data_q;

    fpd_field_split #(.HALF_W(HALF_W), .CH_W(CH_W)) u_split (
        .raw      (byte_in),
        .is_lower (b_lower),
        .chan     (b_chan),
        .data     (b_data)
    );

    fpd_pair_track #(.HALF_W(HALF_W), .CH_W(CH_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .vld         (byte_vld),
        .is_lower    (b_lower),
        .chan        (b_chan),
        .data        (b_data),
        .ev          (ev),
        .pend_q      (pend_q),
        .pend_chan_q (pend_chan_q),
        .pend_data_q (pend_data_q)
    );

    fpd_emit #(.HALF_W(HALF_W), .CH_W(CH_W)) u_emit (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .hi_data  (pend_data_q),
        .lo_data  (b_data),
        .chan     (b_chan),
        .smp_stb  (smp_stb),
        .smp_val  (smp_val),
        .smp_chan (smp_chan),
        .err_stb  (err_stb)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!smp_stb && !err_stb && !pend_q));

    // R3
    pair_out_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_in[BYTE_W-1] && pend_q && byte_in[BYTE_W-2 -: CH_W] == pend_chan_q)
        |=> (smp_stb && smp_val == {$past(pend_data_q), $past(byte_in[HALF_W-1:0])}
             && smp_chan == $past(pend_chan_q)));

    // R5
    orphan_err_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_in[BYTE_W-1] && !pend_q) |=> (err_stb && !smp_stb));

    // R7
    replace_err_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !byte_in[BYTE_W-1] && pend_q) |=> err_stb);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> (!smp_stb && !err_stb && $stable(smp_val)));
endmodule

// File: tb/sim_frame_pair_decoder.sv
module sim_frame_pair_decoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       smp_stb;
    logic [9:0] smp_val;
    logic [1:0] smp_chan;
    logic       err_stb;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_pair_decoder u0 (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .smp_stb(smp_stb), .smp_val(smp_val), .smp_chan(smp_chan), .err_stb(err_stb)
    );

    // R2 layout: bit7 half flag, bits6:5 channel, bits4:0 data
    function automatic logic [7:0] mk(input int lower, input int ch, input int d);
        return {lower[0], ch[1:0], d[4:0]};
    endfunction

    // Drive at a falling edge, return at the next falling edge (outputs then reflect it)
    task automatic step(input logic v, input logic [7:0] b);
        byte_vld = v;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic ev, input logic ee,
                              input int es, input int ec);
        checks++;
        if (smp_stb !== ev || err_stb !== ee ||
            (ev && (int'(smp_val) != es || int'(smp_chan) != ec))) begin
            failures++;
            $display("FAIL %s: got stb=%0b err=%0b val=%0d ch=%0d exp stb=%0b err=%0b val=%0d ch=%0d",
                     req, smp_stb, err_stb, smp_val, smp_chan, ev, ee, es, ec);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: valid byte during reset has no effect
        step(1'b1, mk(0, 1, 7));
        step(1'b1, mk(1, 1, 7));
        expect_out("R1 reset outputs", 0, 0, 0, 0);
        rst = 1'b0;
        step(1'b0, 8'h00);
        expect_out("R1 after release", 0, 0, 0, 0);
        // R1/R5: first byte a lower half -> orphan
        step(1'b1, mk(1, 1, 7));
        expect_out("R1 pending clear, R5 orphan", 0, 1, 0, 0);
        step(1'b0, 8'h00);
        expect_out("R9 single pulse", 0, 0, 0, 0);

        // R10 worked example
        step(1'b1, 8'h71);
        expect_out("R10 upper", 0, 0, 0, 0);
        step(1'b1, 8'hF4);
        expect_out("R10 value 564", 1, 0, 564, 3);
        step(1'b0, 8'h00);
        expect_out("R9 sample single pulse", 0, 0, 0, 0);

        // R3 exhaustive sweep, back to back
        for (int ch = 0; ch < 4; ch++)
            for (int u = 0; u < 32; u++)
                for (int l = 0; l < 32; l++) begin
                    step(1'b1, mk(0, ch, u));
                    expect_out("R3 upper no output", 0, 0, 0, 0);
                    step(1'b1, mk(1, ch, l));
                    expect_out("R3 pair", 1, 0, u * 32 + l, ch);
                end

        // R4 channel order shuffled
        for (int k = 0; k < 8; k++) begin
            int ch = (k * 3 + 1) % 4;
            step(1'b1, mk(0, ch, k + 20));
            step(1'b1, mk(1, ch, 31 - k));
            expect_out("R4 any order", 1, 0, (k + 20) * 32 + 31 - k, ch);
        end

        // R6 mismatched channel, all pairs
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                if (a == b) continue;
                step(1'b1, mk(0, a, 9));
                step(1'b1, mk(1, b, 4));
                expect_out("R6 mismatch error", 0, 1, 0, 0);
                step(1'b1, mk(1, a, 4));
                expect_out("R6 flushed then orphan", 0, 1, 0, 0);
            end

        // R7 upper replaced by upper of another channel
        step(1'b1, mk(0, 0, 5));
        step(1'b1, mk(0, 2, 9));
        expect_out("R7 replace error", 0, 1, 0, 0);
        step(1'b1, mk(1, 2, 3));
        expect_out("R7 pairs with newer", 1, 0, 9 * 32 + 3, 2);
        // R7 same channel replaced
        step(1'b1, mk(0, 1, 1));
        step(1'b1, mk(0, 1, 30));
        expect_out("R7 same chan replace error", 0, 1, 0, 0);
        step(1'b1, mk(1, 1, 17));
        expect_out("R7 newer data used", 1, 0, 30 * 32 + 17, 1);

        // R8 idle cycles and ignored bus contents
        step(1'b1, mk(0, 3, 12));
        step(1'b0, mk(1, 0, 2));
        expect_out("R8 idle no output", 0, 0, 0, 0);
        step(1'b0, mk(0, 3, 1));
        step(1'b0, mk(1, 3, 1));
        expect_out("R8 idle ignored", 0, 0, 0, 0);
        step(1'b1, mk(1, 3, 6));
        expect_out("R8 pair survives idle", 1, 0, 12 * 32 + 6, 3);

        // R1 mid-run reset flushes a pending upper half
        step(1'b1, mk(0, 2, 8));
        rst = 1'b1;
        step(1'b0, 8'h00);
        rst = 1'b0;
        expect_out("R1 reset mid-run", 0, 0, 0, 0);
        step(1'b1, mk(1, 2, 8));
        expect_out("R1 pending cleared by reset", 0, 1, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule